// File: doc/BRIEF.md
# Card-Change Interrupt Latch

This block sits between a removable-card slot and the command bridge that serves a host. It watches the slot's card-detect switch, an active-low signal that reads low while a card is seated. Whenever that signal changes, on insertion or on removal, it sets a sticky interrupt latch. The latch drives an active-low, open-drain interrupt line back to the host. While the latch is clear, the line is left floating.

The host reacts by issuing the card-present query command. The bridge decodes that command and pulses a one-cycle clear strobe into this block, and the strobe releases the interrupt line. The block also reports a registered present flag, which the bridge returns as the answer to the query.

Card-detect changes are only watched while the bridge is idle. A change that happens while a command is running is absorbed into the reference state and is never reported. The card-detect input is assumed to be already synchronised to the clock. Debouncing is left to the host side.

Top module: `card_change_irq`

## Requirements
- R1: `present_o` is 1 when `card_det_n` is low (card present) and 0 when it is high (absent), and it follows the input one clock later.
- R2: An insertion (`card_det_n` going 1 to 0) sampled while `cmd_busy` is low sets the latch, so `irq_pull_o` is 1 after the next clock edge.
- R3: A removal (`card_det_n` going 0 to 1) sampled while `cmd_busy` is low sets the latch in the same way.
- R4: `irq_pull_o` (1 means pull the open-drain line low, 0 means high impedance) is 1 only while the latch is set. It stays set until a clear strobe arrives, and it stays clear until a new change is seen.
- R5: A card-detect change sampled while `cmd_busy` is high does not set the latch. It is also not reported later, after `cmd_busy` falls.
- R6: A one-cycle `query_clr` pulse with no concurrent change releases `irq_pull_o` after the next clock edge.
- R7: A card-detect change and a `query_clr` pulse in the same cycle leave the latch set.
- R8: Synchronous reset clears the latch, releases `irq_pull_o` and drives `present_o` to 0. The first card-detect sample after reset only loads the reference and is never counted as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| card_det_n | input | 1 | Synchronised card-detect switch, low = card present |
| cmd_busy | input | 1 | High while the bridge executes a host command |
| query_clr | input | 1 | One-cycle strobe from the card-present query command |
| irq_pull_o | output | 1 | Open-drain enable: 1 pulls the interrupt line low |
| present_o | output | 1 | Registered card status, 1 = present |

## Verification
The properties assume that `card_det_n`, `cmd_busy` and `query_clr` are already synchronous to `clk`. They also assume the inputs hold steady through each sampling edge, so every change is seen at exactly one edge.

The bench drives all inputs on the falling edge, so each value is stable around the rising edge that samples it. Card-detect toggles are kept sparse, as a debounced switch would be. Busy windows and clear strobes are mixed in so that changes fall inside commands, outside commands and on the same cycle as a clear.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  // Reference of the last card-detect sample seen by the edge watcher.
  typedef struct packed {
    logic valid;  // a sample has been taken since reset
    logic level;  // raw pin level of that sample
  } cd_ref_t;

  localparam cd_ref_t CD_REF_RESET = '{valid: 1'b0, level: 1'b1};
endpackage

// File: rtl/cdl_edge_watch.sv
module cdl_edge_watch
  import cdl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cd_level,
  input  logic mask,
  output logic change_o
);
  cd_ref_t ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= CD_REF_RESET;
    end else begin
      // The reference follows the pin even while masked,
      // so a masked change is absorbed rather than deferred.
      ref_q.level <= cd_level;
      ref_q.valid <= 1'b1;
    end
  end

  assign change_o = ref_q.valid && (cd_level != ref_q.level) && !mask;
endmodule

// File: rtl/cdl_irq_latch.sv
module cdl_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst)        hold_q <= 1'b0;
    else if (set_i) hold_q <= 1'b1;  // set wins over clear
    else if (clr_i) hold_q <= 1'b0;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/cdl_status_reg.sv
module cdl_status_reg #(
  parameter bit PRESENT_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic cd_level,
  output logic present_o
);
  logic present_q;

  always_ff @(posedge clk) begin
    if (rst) present_q <= 1'b0;
    else     present_q <= (cd_level == PRESENT_LEVEL);
  end

  assign present_o = present_q;
endmodule

// File: rtl/card_change_irq.sv
module card_change_irq #(
  parameter bit PRESENT_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic card_det_n,
  input  logic cmd_busy,
  input  logic query_clr,
  output logic irq_pull_o,
  output logic present_o
);
  logic change;

  cdl_edge_watch u_edge (
    .clk      (clk),
    .rst      (rst),
    .cd_level (card_det_n),
    .mask     (cmd_busy),
    .change_o (change)
  );

  cdl_irq_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .set_i  (change),
    .clr_i  (query_clr),
    .hold_o (irq_pull_o)
  );

  cdl_status_reg #(.PRESENT_LEVEL(PRESENT_LEVEL)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .cd_level  (card_det_n),
    .present_o (present_o)
  );
endmodule

// File: rtl/cdl_checker.sv
module cdl_checker (
  input logic clk,
  input logic rst,
  input logic card_det_n,
  input logic cmd_busy,
  input logic query_clr,
  input logic irq_pull_o,
  input logic present_o
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // Idle-time change: current pin differs from last cycle, reference valid.
  p_insert_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !cmd_busy && !card_det_n && $past(card_det_n)) |=> irq_pull_o);

  p_remove_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !cmd_busy && card_det_n && !$past(card_det_n)) |=> irq_pull_o);

  p_hold_until_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_pull_o && !query_clr) |=> irq_pull_o);

  p_busy_masks_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_busy && !query_clr && !irq_pull_o) |=> !irq_pull_o);

  p_clear_releases_r6: assert property (@(posedge clk) disable iff (rst)
    (query_clr && (cmd_busy || $past(rst) || (card_det_n == $past(card_det_n))))
      |=> !irq_pull_o);

  p_present_follows_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (present_o == !$past(card_det_n)));

  always_ff @(posedge clk) begin
    if (rst_seen) begin
      p_reset_release_r8: assert (!irq_pull_o && !present_o);
    end
  end
endmodule

bind card_change_irq cdl_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .card_det_n (card_det_n),
  .cmd_busy   (cmd_busy),
  .query_clr  (query_clr),
  .irq_pull_o (irq_pull_o),
  .present_o  (present_o)
);

// File: tb/sim_card_change_irq.sv
module sim_card_change_irq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic card_det_n = 1'b1;
  logic cmd_busy = 1'b0;
  logic query_clr = 1'b0;
  logic irq_pull_o;
  logic present_o;

  always #4 clk = ~clk;  // 125 MHz

  card_change_irq u0 (
    .clk        (clk),
    .rst        (rst),
    .card_det_n (card_det_n),
    .cmd_busy   (cmd_busy),
    .query_clr  (query_clr),
    .irq_pull_o (irq_pull_o),
    .present_o  (present_o)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Bench model state
  bit m_latch = 1'b0;
  bit m_valid = 1'b0;
  bit m_prev = 1'b1;
  bit m_pres = 1'b0;

  function automatic bit next_latch(bit latch, bit valid, bit prev,
                                    bit cd, bit busy, bit clr);
    bit chg;
    chg = valid && (cd != prev) && !busy;
    if (chg) return 1'b1;
    if (clr) return 1'b0;
    return latch;
  endfunction

  task automatic check(string tag, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then check at the next falling edge.
  task automatic step(bit r, bit cd, bit busy, bit clr);
    string tag;
    bit chg;
    rst = r; card_det_n = cd; cmd_busy = busy; query_clr = clr;
    if (r) begin
      tag = "R8";
      m_latch = 1'b0; m_valid = 1'b0; m_prev = cd; m_pres = 1'b0;
    end else begin
      chg = m_valid && (cd != m_prev);
      if (chg && busy)      tag = "R5";
      else if (chg && clr)  tag = "R7";
      else if (chg && !cd)  tag = "R2";
      else if (chg)         tag = "R3";
      else if (clr)         tag = "R6";
      else if (!m_valid)    tag = "R8";
      else                  tag = "R4";
      m_latch = next_latch(m_latch, m_valid, m_prev, cd, busy, clr);
      m_prev = cd; m_valid = 1'b1; m_pres = !cd;
    end
    @(negedge clk);
    check(tag, irq_pull_o, m_latch, "irq_pull_o");
    check(r ? "R8" : "R1", present_o, m_pres, "present_o");
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // Reset with a card already seated: the first sample must not count (R8)
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // Removal while idle (R3), hold (R4), clear (R6)
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    step(0, 1, 1, 1);
    step(0, 1, 0, 0);
    // Insertion while idle (R2) then clear
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    // Change inside a command, then command ends: never reported (R5)
    step(0, 0, 1, 0);
    step(0, 1, 1, 0);
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    // Change and clear on the same cycle (R7)
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 1);
    // Reset while the latch is set (R8)
    step(0, 1, 0, 0);
    step(1, 1, 0, 0);
    step(0, 1, 0, 0);
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      bit cd, busy, clr;
      cd   = (($urandom % 10) == 0) ? !card_det_n : card_det_n;
      busy = (($urandom % 10) < 3);
      clr  = (($urandom % 10) == 0);
      step((($urandom % 500) == 0), cd, busy, clr);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule